// File: doc/BRIEF.md
# Four-Channel DMA Bus Scheduler with Pair Chaining

This block sits above four DMA channel engines and decides which of them owns the shared bus for its next burst. Each channel raises a request while it has a burst ready. The scheduler returns a registered one-hot grant that the channel keeps until it reports the end of that burst. Arbitration therefore happens only at burst boundaries. Three priority schemes can be selected at run time: strict fixed order, round-robin over all channels, and a hybrid where channel 0 always wins and channels 1 to 3 share the rest in rotation.

The scheduler can also chain channels to keep a data stream running. Channels 0 and 1 form one pair, and channels 2 and 3 form the other. When chaining is enabled for a pair and one of its channels reports that its whole transaction is finished, the scheduler sends a one-cycle enable pulse to the other channel of the pair. The hand-off works in both directions, so the two channels take turns indefinitely. Address generation, byte counters and the data path stay inside the channel engines.

Top module: `dmas_sched`

## Requirements
- R1: After reset the grant output and all enable pulses are zero. At every clock the grant output has at most one bit set.
- R2: The bus is free when no grant is held, or when the current owner raises its burst_done_i bit. In that case, on the next clock edge the grant moves to one channel whose req_i bit is set. If no request is pending, the grant becomes all-zero. A channel without a request is never granted.
- R3: A granted channel keeps its grant unchanged until its own burst_done_i bit is high. burst_done_i bits of channels that do not hold the grant have no effect.
- R4: With prio_mode_i = 0 or 3 (fixed), the lowest-numbered requesting channel wins.
- R5: With prio_mode_i = 1 (rotating), the winner is the first requesting channel in ascending order after the most recently granted channel, wrapping from 3 to 0. After reset the search starts at channel 0.
- R6: With prio_mode_i = 2 (hybrid), channel 0 wins whenever it requests. Otherwise channels 1 to 3 rotate in ascending order after the last of them that was granted. Grants to channel 0 do not move this rotation.
- R7: When the bus is free and no request is pending, the rotation position does not move. The next winner depends only on grants that were actually issued.
- R8: link_en_i bit 0 chains channels 0 and 1, and bit 1 chains channels 2 and 3. When txn_done_i of a channel is high and its pair's bit is set, en_pulse_o of the other channel in that pair goes high in the next cycle, for one cycle.
- R9: When a pair's link_en_i bit is clear, txn_done_i of its channels produces no enable pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 4 | Per-channel burst request |
| burst_done_i | input | 4 | Per-channel end-of-burst strobe |
| txn_done_i | input | 4 | Per-channel end-of-transaction strobe |
| prio_mode_i | input | 2 | 0/3 fixed, 1 rotating, 2 channel 0 fixed plus rotation |
| link_en_i | input | 2 | Chaining enable per channel pair |
| gnt_o | output | 4 | One-hot bus grant, or all-zero |
| en_pulse_o | output | 4 | One-cycle enable pulse to the chained partner |

## Verification
The fixed scheme is tested with all channels requesting. This separates lowest-index selection from rotation, and releases from non-owners show whether they are ignored. The rotating scheme is tested with continuous full requests, which should give a clean 0-1-2-3-0 cycle. An idle gap followed by a sparse request pattern then shows whether the rotation position moved without a grant. The hybrid scheme alternates channel 0 requesting and not requesting, which shows whether its wins disturb the rotation of the other three. Chaining is tested in both directions within a pair, with the pair bit clear, and for the second pair.

// File: rtl/dmas_pkg.sv
package dmas_pkg;
  typedef enum logic [1:0] {
    PRIO_FIXED     = 2'd0,
    PRIO_ROTATE    = 2'd1,
    PRIO_HYBRID    = 2'd2,
    PRIO_FIXED_ALT = 2'd3
  } prio_mode_e;
endpackage

// File: rtl/dmas_arb.sv
module dmas_arb
  import dmas_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] req_i,
  input  logic [NCH-1:0] burst_done_i,
  input  prio_mode_e     mode_i,
  output logic [NCH-1:0] gnt_o
);
  localparam int IW = $clog2(NCH);

  logic [NCH-1:0] gnt_q;
  logic [IW-1:0]  last_q;
  logic [IW-1:0]  win_idx;
  logic           found;
  logic           free;

  assign free = ~(|gnt_q) | (|(gnt_q & burst_done_i));

  always_comb begin
    found   = 1'b0;
    win_idx = last_q;
    unique case (mode_i)
      PRIO_ROTATE: begin
        for (int k = 0; k < NCH; k++) begin
          if (!found && req_i[last_q + IW'(k + 1)]) begin
            found   = 1'b1;
            win_idx = last_q + IW'(k + 1);
          end
        end
      end
      PRIO_HYBRID: begin
        if (req_i[0]) begin
          found   = 1'b1;
          win_idx = '0;
        end else begin
          for (int k = 0; k < NCH; k++) begin
            if (!found && (last_q + IW'(k + 1)) != '0 && req_i[last_q + IW'(k + 1)]) begin
              found   = 1'b1;
              win_idx = last_q + IW'(k + 1);
            end
          end
        end
      end
      default: begin
        for (int k = 0; k < NCH; k++) begin
          if (!found && req_i[k]) begin
            found   = 1'b1;
            win_idx = IW'(k);
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gnt_q  <= '0;
      last_q <= IW'(NCH - 1);
    end else if (free) begin
      gnt_q <= found ? (NCH'(1) << win_idx) : '0;
      // hybrid: channel 0 wins stay out of the rotation
      if (found && !(mode_i == PRIO_HYBRID && win_idx == '0)) last_q <= win_idx;
    end
  end

  assign gnt_o = gnt_q;

  AST_GNT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_q)); // R1
  AST_GNT_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    free |=> (gnt_q & ~$past(req_i)) == '0); // R2
  AST_GNT_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    free && (|req_i) |=> |gnt_q); // R2
  AST_GNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|gnt_q) && !(|(gnt_q & burst_done_i)) |=> gnt_q == $past(gnt_q)); // R3
  AST_FIXED_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    free && (mode_i == PRIO_FIXED || mode_i == PRIO_FIXED_ALT) && req_i[0] |=> gnt_q[0]); // R4
  AST_HYB_CH0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    free && mode_i == PRIO_HYBRID && req_i[0] |=> gnt_q[0]); // R6
  AST_PTR_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    free && !(|req_i) |=> $stable(last_q)); // R7
endmodule

// File: rtl/dmas_link.sv
module dmas_link #(
  parameter int NCH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NCH-1:0]   txn_done_i,
  input  logic [NCH/2-1:0] link_en_i,
  output logic [NCH-1:0]   en_pulse_o
);
  logic [NCH-1:0] hand_d;
  logic [NCH-1:0] en_q;

  for (genvar c = 0; c < NCH; c++) begin : g_pair
    // partner of c is c^1; both share link bit c/2
    assign hand_d[c] = txn_done_i[c ^ 1] & link_en_i[c / 2];

    AST_LINK_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      txn_done_i[c] && link_en_i[c / 2] |=> en_pulse_o[c ^ 1]); // R8
    AST_LINK_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !link_en_i[c / 2] |=> !en_pulse_o[c]); // R9
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= '0;
    else         en_q <= hand_d;
  end

  assign en_pulse_o = en_q;
endmodule

// File: rtl/dmas_sched.sv
module dmas_sched
  import dmas_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NCH-1:0]   req_i,
  input  logic [NCH-1:0]   burst_done_i,
  input  logic [NCH-1:0]   txn_done_i,
  input  logic [1:0]       prio_mode_i,
  input  logic [NCH/2-1:0] link_en_i,
  output logic [NCH-1:0]   gnt_o,
  output logic [NCH-1:0]   en_pulse_o
);
  prio_mode_e mode;
  assign mode = prio_mode_e'(prio_mode_i);

  dmas_arb #(.NCH(NCH)) u_arb (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_i        (req_i),
    .burst_done_i (burst_done_i),
    .mode_i       (mode),
    .gnt_o        (gnt_o)
  );

  dmas_link #(.NCH(NCH)) u_link (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .txn_done_i (txn_done_i),
    .link_en_i  (link_en_i),
    .en_pulse_o (en_pulse_o)
  );

  AST_RST_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> gnt_o == '0 && en_pulse_o == '0); // R1
endmodule

// File: tb/dmas_sched_tb.sv
module dmas_sched_tb;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] req = '0, bdone = '0, tdone = '0;
  logic [1:0] mode = '0, link = '0;
  logic [3:0] gnt, enp;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  dmas_sched u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .burst_done_i(bdone),
    .txn_done_i(tdone), .prio_mode_i(mode), .link_en_i(link),
    .gnt_o(gnt), .en_pulse_o(enp)
  );

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%b exp=%b", tag, act, exp);
    end
  endtask

  task automatic step(input logic [3:0] r, input logic [3:0] b, input logic [3:0] t);
    @(negedge clk);
    req = r; bdone = b; tdone = t;
    @(posedge clk); #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; req = '0; bdone = '0; tdone = '0;
    @(negedge clk); @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic t_reset();
    do_reset();
    #1;
    chk("R1 gnt after reset", gnt, 4'b0000);
    chk("R1 pulse after reset", enp, 4'b0000);
  endtask

  task automatic t_fixed();
    do_reset(); mode = 2'd0;
    step(4'b1111, 4'b0000, 4'b0000); chk("R4 fixed first", gnt, 4'b0001);
    step(4'b1111, 4'b0100, 4'b0000); chk("R3 non-owner done ignored", gnt, 4'b0001);
    step(4'b1110, 4'b0001, 4'b0000); chk("R4 fixed next", gnt, 4'b0010);
    step(4'b1100, 4'b0010, 4'b0000); chk("R4 fixed third", gnt, 4'b0100);
    step(4'b0000, 4'b0100, 4'b0000); chk("R2 no req no grant", gnt, 4'b0000);
    mode = 2'd3;
    step(4'b1100, 4'b0000, 4'b0000); chk("R4 alt fixed", gnt, 4'b0100);
    step(4'b0000, 4'b0100, 4'b0000); chk("R2 release", gnt, 4'b0000);
  endtask

  task automatic t_rotate();
    do_reset(); mode = 2'd1;
    step(4'b1111, 4'b0000, 4'b0000); chk("R5 start ch0", gnt, 4'b0001);
    step(4'b1111, 4'b0001, 4'b0000); chk("R5 to ch1", gnt, 4'b0010);
    step(4'b1111, 4'b0010, 4'b0000); chk("R5 to ch2", gnt, 4'b0100);
    step(4'b1111, 4'b0100, 4'b0000); chk("R5 to ch3", gnt, 4'b1000);
    step(4'b1111, 4'b1000, 4'b0000); chk("R5 wrap ch0", gnt, 4'b0001);
    step(4'b0000, 4'b0001, 4'b0000); chk("R2 idle", gnt, 4'b0000);
    step(4'b0000, 4'b0000, 4'b0000);
    step(4'b0000, 4'b0000, 4'b0000); chk("R7 still idle", gnt, 4'b0000);
    step(4'b1010, 4'b0000, 4'b0000); chk("R7 pointer kept", gnt, 4'b0010);
    step(4'b1010, 4'b0010, 4'b0000); chk("R5 sparse next", gnt, 4'b1000);
    step(4'b0000, 4'b1000, 4'b0000);
  endtask

  task automatic t_hybrid();
    do_reset(); mode = 2'd2;
    step(4'b1111, 4'b0000, 4'b0000); chk("R6 ch0 first", gnt, 4'b0001);
    step(4'b1110, 4'b0001, 4'b0000); chk("R6 rot ch1", gnt, 4'b0010);
    step(4'b1111, 4'b0010, 4'b0000); chk("R6 ch0 again", gnt, 4'b0001);
    step(4'b1110, 4'b0001, 4'b0000); chk("R6 rot ch2", gnt, 4'b0100);
    step(4'b1110, 4'b0100, 4'b0000); chk("R6 rot ch3", gnt, 4'b1000);
    step(4'b1110, 4'b1000, 4'b0000); chk("R6 wrap ch1", gnt, 4'b0010);
    step(4'b0000, 4'b0010, 4'b0000);
  endtask

  task automatic t_link();
    do_reset(); mode = 2'd0; link = 2'b01;
    step(4'b0000, 4'b0000, 4'b0001); chk("R8 0 to 1", enp, 4'b0010);
    step(4'b0000, 4'b0000, 4'b0000); chk("R8 single pulse", enp, 4'b0000);
    step(4'b0000, 4'b0000, 4'b0010); chk("R8 1 back to 0", enp, 4'b0001);
    step(4'b0000, 4'b0000, 4'b0100); chk("R9 pair off", enp, 4'b0000);
    step(4'b0000, 4'b0000, 4'b0000); chk("R9 still none", enp, 4'b0000);
    link = 2'b11;
    step(4'b0000, 4'b0000, 4'b1000); chk("R8 3 to 2", enp, 4'b0100);
    step(4'b0000, 4'b0000, 4'b0000);
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_fixed();
    t_rotate();
    t_hybrid();
    t_link();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule